// File: doc/BRIEF.md
# Two-Channel DMA Controller

This block moves data on behalf of the CPU over a single-master memory bus that both of them share. It has two channels. Software programs each one with a start source address, a start destination address, a unit count and a mode word. A selected trigger line, or a software kick, asks the channel to move one unit: a byte or a 16-bit word, read from the source and then written to the destination.

For every request the engine raises a bus request and waits for the grant. It then issues one read cycle and one write cycle, and drops the request so that the CPU gets the bus back. Each address either advances or stays fixed. When the count runs out, a single-mode channel disables itself. A repeat-mode channel reloads its start values and keeps running. Either way the channel pulses its interrupt line.

Top module: `dma2ch`

## Requirements
- R1: After synchronous reset every register reads 0, `bus_req`, `mem_re`, `mem_we` and `irq` are 0, and no request is pending.
- R2: Register address is {channel, index}: index 0 source address, 1 destination address, 2 count, 3 mode. Mode bits are: bit 0 enable, bit 1 word size, bit 2 repeat, bit 3 source increment, bit 4 destination increment, bits 7:5 cause. `reg_rdata` shows the register at `reg_raddr` one cycle later. Writing an address or the count also stores it as the reload value.
- R3: Cause code c in 0,1,3,4,5 makes `hw_req[c]` a request line. Cause code 2 is the software trigger: a mode write with bit 8 set. Codes 6 and 7 never trigger, and lines other than the selected one have no effect.
- R4: Each accepted request moves exactly one unit. The unit is a read of the source with `mem_re` (data returns on `mem_rdata` one cycle later), then a write of that data to the destination with `mem_we`. A byte unit writes the low 8 bits with the high bits zero and `mem_word`=0.
- R5: After a unit, an address with its increment bit set advances by 1 (byte) or 2 (word). An address with its increment bit clear stays fixed.
- R6: Each unit lowers the count by one. When a single-mode channel reaches zero, it clears its enable bit and pulses its `irq` bit for exactly one cycle.
- R7: When a repeat-mode channel finishes the unit that would bring its count to zero, it reloads count, source and destination from the last written values, stays enabled, and pulses `irq` for one cycle.
- R8: Each channel holds at most one pending request. Requests that arrive while one is already pending are merged into it. A request that arrives in the cycle its pending flag is taken is kept.
- R9: When both channels are pending, channel 0 is served first.
- R10: `bus_req` stays high from the start of a unit to its write. No read starts before `bus_gnt`. `bus_req` is low for at least one cycle between two units.
- R11: A channel with enable clear ignores all requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register write address {channel, index} |
| reg_wdata | input | 16 | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | 16 | Registered read data |
| hw_req | input | 6 | Request lines, indexed by cause code |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant |
| mem_addr | output | 16 | Memory address |
| mem_re | output | 1 | Read cycle strobe |
| mem_we | output | 1 | Write cycle strobe |
| mem_word | output | 1 | 1 for a 16-bit unit, 0 for a byte |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_re` |
| irq | output | 2 | One-cycle completion pulse per channel |

## Verification
The hardest cases to reach from the ports are the merging and collision cases: a request that lands in the very cycle the channel's pending flag is being taken, and both channels becoming pending in the same cycle. The bench reaches the first by holding one request line high for three consecutive clocks. It then expects two units, not one or three. It reaches the second by giving both channels the same cause line and pulsing that line once, then reading the write-address log. A grant the bench withholds on purpose shows that no read starts without the bus.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int CAUSE_W   = 3;
  localparam int NUM_CAUSE = 6;
  localparam int CAUSE_SW  = 2;
  localparam int MODE_W    = 8;
  localparam int SW_BIT    = 8;

  localparam logic [1:0] IDX_SRC  = 2'd0;
  localparam logic [1:0] IDX_DST  = 2'd1;
  localparam logic [1:0] IDX_CNT  = 2'd2;
  localparam logic [1:0] IDX_MODE = 2'd3;

  typedef struct packed {
    logic [CAUSE_W-1:0] cause;
    logic               dinc;
    logic               sinc;
    logic               rpt;
    logic               word;
    logic               en;
  } mode_t;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_RD, S_LAT, S_WR
  } eng_st_t;
endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [1:0]           wr_idx,
  input  logic [DW-1:0]        wdata,
  input  logic [NUM_CAUSE-1:0] hw_req,
  input  logic                 take,
  input  logic                 done,
  output logic [AW-1:0]        src,
  output logic [AW-1:0]        dst,
  output logic [DW-1:0]        cnt,
  output mode_t                mode,
  output logic                 pend,
  output logic                 irq
);
  localparam int PAD_W = 2**CAUSE_W;

  logic [AW-1:0] src_sh, dst_sh;
  logic [DW-1:0] cnt_sh;
  logic [PAD_W-1:0] req_pad;
  mode_t wmode;
  logic mode_wr, en_now, sw_hit, hit, trig, last, kill;
  logic [CAUSE_W-1:0] cause_now;
  logic [AW-1:0] step;

  assign req_pad   = {{(PAD_W-NUM_CAUSE){1'b0}}, hw_req};
  assign wmode     = mode_t'(wdata[MODE_W-1:0]);
  assign mode_wr   = wr_en && (wr_idx == IDX_MODE);
  assign en_now    = mode_wr ? wmode.en : mode.en;
  assign cause_now = mode_wr ? wmode.cause : mode.cause;
  assign sw_hit    = mode_wr && wdata[SW_BIT];
  assign hit       = (cause_now == CAUSE_W'(CAUSE_SW)) ? sw_hit : req_pad[cause_now];
  assign trig      = en_now && hit;
  assign last      = (cnt == DW'(1));
  assign kill      = done && last && !mode.rpt;
  assign step      = mode.word ? AW'(2) : AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      src <= '0; dst <= '0; cnt <= '0;
      src_sh <= '0; dst_sh <= '0; cnt_sh <= '0;
      mode <= '0; pend <= 1'b0; irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (done) begin
        if (last) irq <= 1'b1;
        if (last && mode.rpt) begin
          src <= src_sh;
          dst <= dst_sh;
          cnt <= cnt_sh;
        end else begin
          cnt <= cnt - DW'(1);
          if (mode.sinc) src <= src + step;
          if (mode.dinc) dst <= dst + step;
          if (last) mode.en <= 1'b0;
        end
      end
      if (take || kill || (mode_wr && !wmode.en)) pend <= 1'b0;
      if (trig && !kill) pend <= 1'b1;
      if (wr_en) begin
        case (wr_idx)
          IDX_SRC: begin src <= wdata[AW-1:0]; src_sh <= wdata[AW-1:0]; end
          IDX_DST: begin dst <= wdata[AW-1:0]; dst_sh <= wdata[AW-1:0]; end
          IDX_CNT: begin cnt <= wdata; cnt_sh <= wdata; end
          default: mode <= wmode;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int NCH = 2,
  parameter int IW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] pend,
  output logic [NCH-1:0] win,
  output logic [IW-1:0]  win_idx,
  output logic           any
);
  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_pri
      if (gi == 0) begin : g_top
        assign win[gi] = pend[gi];
      end else begin : g_low
        assign win[gi] = pend[gi] && !(|pend[gi-1:0]);
      end
    end
  endgenerate

  assign any = |pend;

  always_comb begin
    win_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (win[i]) win_idx = IW'(i);
    end
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int IW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           any,
  input  logic [NCH-1:0] win,
  input  logic [IW-1:0]  win_idx,
  input  logic [AW-1:0]  sel_src,
  input  logic [AW-1:0]  sel_dst,
  input  logic           sel_word,
  input  logic           bus_gnt,
  input  logic [DW-1:0]  mem_rdata,
  output logic [IW-1:0]  cur,
  output logic [NCH-1:0] take,
  output logic [NCH-1:0] done,
  output logic           bus_req,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_re,
  output logic           mem_we,
  output logic           mem_word,
  output logic [DW-1:0]  mem_wdata
);
  eng_st_t st;

  assign take = (st == S_IDLE && any) ? win : '0;

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_done
      assign done[gi] = (st == S_WR) && (cur == IW'(gi));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; cur <= '0; bus_req <= 1'b0;
      mem_addr <= '0; mem_re <= 1'b0; mem_we <= 1'b0;
      mem_word <= 1'b0; mem_wdata <= '0;
    end else begin
      case (st)
        S_IDLE: if (any) begin
          cur     <= win_idx;
          bus_req <= 1'b1;
          st      <= S_WAIT;
        end
        S_WAIT: if (bus_gnt) begin
          mem_re   <= 1'b1;
          mem_addr <= sel_src;
          mem_word <= sel_word;
          st       <= S_RD;
        end
        S_RD: begin
          mem_re <= 1'b0;
          st     <= S_LAT;
        end
        S_LAT: begin
          mem_wdata <= mem_word ? mem_rdata : {{(DW-8){1'b0}}, mem_rdata[7:0]};
          mem_we    <= 1'b1;
          mem_addr  <= sel_dst;
          st        <= S_WR;
        end
        default: begin
          mem_we  <= 1'b0;
          bus_req <= 1'b0;
          st      <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/dma2ch.sv
module dma2ch
  import dma_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 16,
  parameter int DW  = 16,
  localparam int IW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RAW = IW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_we,
  input  logic [RAW-1:0]       reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  input  logic [RAW-1:0]       reg_raddr,
  output logic [DW-1:0]        reg_rdata,
  input  logic [NUM_CAUSE-1:0] hw_req,
  output logic                 bus_req,
  input  logic                 bus_gnt,
  output logic [AW-1:0]        mem_addr,
  output logic                 mem_re,
  output logic                 mem_we,
  output logic                 mem_word,
  output logic [DW-1:0]        mem_wdata,
  input  logic [DW-1:0]        mem_rdata,
  output logic [NCH-1:0]       irq
);
  logic [AW-1:0] src_a [NCH];
  logic [AW-1:0] dst_a [NCH];
  logic [DW-1:0] cnt_a [NCH];
  mode_t         mode_a [NCH];
  logic [NCH-1:0] pend, win, take, done;
  logic [IW-1:0]  win_idx, cur, rch;
  logic any;

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_ch
      dma_chan #(.AW(AW), .DW(DW)) u_chan (
        .clk(clk), .rst(rst),
        .wr_en(reg_we && (reg_addr[RAW-1:2] == IW'(gi))),
        .wr_idx(reg_addr[1:0]), .wdata(reg_wdata), .hw_req(hw_req),
        .take(take[gi]), .done(done[gi]),
        .src(src_a[gi]), .dst(dst_a[gi]), .cnt(cnt_a[gi]), .mode(mode_a[gi]),
        .pend(pend[gi]), .irq(irq[gi])
      );
    end
  endgenerate

  dma_arb #(.NCH(NCH), .IW(IW)) u_arb (
    .pend(pend), .win(win), .win_idx(win_idx), .any(any)
  );

  dma_engine #(.NCH(NCH), .AW(AW), .DW(DW), .IW(IW)) u_eng (
    .clk(clk), .rst(rst), .any(any), .win(win), .win_idx(win_idx),
    .sel_src(src_a[cur]), .sel_dst(dst_a[cur]), .sel_word(mode_a[cur].word),
    .bus_gnt(bus_gnt), .mem_rdata(mem_rdata), .cur(cur), .take(take), .done(done),
    .bus_req(bus_req), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_word(mem_word), .mem_wdata(mem_wdata)
  );

  assign rch = reg_raddr[RAW-1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_raddr[1:0])
        IDX_SRC: reg_rdata <= DW'(src_a[rch]);
        IDX_DST: reg_rdata <= DW'(dst_a[rch]);
        IDX_CNT: reg_rdata <= cnt_a[rch];
        default: reg_rdata <= DW'(mode_a[rch]);
      endcase
    end
  end
endmodule

// File: rtl/dma2ch_sva.sv
module dma2ch_sva #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           bus_req,
  input logic           bus_gnt,
  input logic           mem_re,
  input logic           mem_we,
  input logic [NCH-1:0] irq
);
  AST_ACCESS_OWNS_BUS: assert property (@(posedge clk) disable iff (rst)
    (mem_re || mem_we) |-> bus_req); // R10
  AST_READ_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_re) |-> $past(bus_gnt)); // R10
  AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we) |-> !bus_req); // R10
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we)); // R4
  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |-> $past(mem_re, 2)); // R4
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (|irq) |=> !(|irq)); // R6
  AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    (|irq) |-> $past(mem_we)); // R6
  AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq)); // R7
endmodule

bind dma2ch dma2ch_sva #(.NCH(NCH)) u_sva (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .mem_re(mem_re), .mem_we(mem_we), .irq(irq)
);

// File: tb/dma2ch_tb.sv
`timescale 1ns/1ps
module dma2ch_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0, reg_raddr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic [5:0] hw_req = '0;
  logic bus_req, bus_gnt, mem_re, mem_we, mem_word;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic [1:0] irq;
  logic gnt_hold = 1'b0;
  logic init_mem = 1'b0;

  always #10 clk = ~clk;
  assign bus_gnt = bus_req && !gnt_hold;

  dma2ch u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .hw_req(hw_req),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr), .mem_re(mem_re),
    .mem_we(mem_we), .mem_word(mem_word), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .irq(irq)
  );

  // memory model and monitors
  logic [7:0] mem [256];
  logic [7:0] expm [256];
  logic [15:0] wlog [64];
  int wtot = 0, retot = 0, irq0 = 0, irq1 = 0;
  int low_run = 0, min_gap = 1000, gaps = 0;
  logic seen_req = 1'b0;

  always @(posedge clk) begin
    if (init_mem) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 37 + 5);
    end else begin
      if (mem_re) begin
        mem_rdata <= mem_word ? {mem[8'(mem_addr + 16'd1)], mem[mem_addr[7:0]]}
                              : {8'h00, mem[mem_addr[7:0]]};
        retot = retot + 1;
      end
      if (mem_we) begin
        mem[mem_addr[7:0]] <= mem_wdata[7:0];
        if (mem_word) mem[8'(mem_addr + 16'd1)] <= mem_wdata[15:8];
        wlog[wtot % 64] = mem_addr;
        wtot = wtot + 1;
      end
    end
    if (irq[0]) irq0 = irq0 + 1;
    if (irq[1]) irq1 = irq1 + 1;
    if (bus_req) begin
      if (seen_req && low_run > 0) begin
        gaps = gaps + 1;
        if (low_run < min_gap) min_gap = low_run;
      end
      seen_req = 1'b1;
      low_run = 0;
    end else if (seen_req) begin
      low_run = low_run + 1;
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_raddr = a;
    @(posedge clk); @(negedge clk); d = reg_rdata;
  endtask

  task automatic pulse(input logic [5:0] m, input int len);
    @(negedge clk); hw_req = m;
    repeat (len) @(negedge clk);
    hw_req = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic fill;
    @(negedge clk); init_mem = 1'b1;
    @(negedge clk); init_mem = 1'b0;
    for (int i = 0; i < 256; i++) expm[i] = 8'(i * 37 + 5);
  endtask

  typedef struct packed {
    logic [2:0] cause;
    logic word, rpt, sinc, dinc;
    logic [7:0] cnt, ntrig, src, dst;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{cause:3'd0, word:1'b0, rpt:1'b0, sinc:1'b1, dinc:1'b1, cnt:8'd4, ntrig:8'd4, src:8'h10, dst:8'h80},
    '{cause:3'd1, word:1'b1, rpt:1'b0, sinc:1'b1, dinc:1'b1, cnt:8'd3, ntrig:8'd2, src:8'h20, dst:8'h90},
    '{cause:3'd3, word:1'b0, rpt:1'b0, sinc:1'b0, dinc:1'b1, cnt:8'd5, ntrig:8'd5, src:8'h30, dst:8'hA0},
    '{cause:3'd4, word:1'b1, rpt:1'b1, sinc:1'b1, dinc:1'b0, cnt:8'd2, ntrig:8'd5, src:8'h40, dst:8'hB0},
    '{cause:3'd5, word:1'b0, rpt:1'b1, sinc:1'b1, dinc:1'b1, cnt:8'd3, ntrig:8'd4, src:8'h50, dst:8'hC0},
    '{cause:3'd2, word:1'b1, rpt:1'b0, sinc:1'b1, dinc:1'b1, cnt:8'd2, ntrig:8'd2, src:8'h60, dst:8'hD0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d, modev;
    logic [7:0] m_src, m_dst, m_cnt;
    logic m_en;
    int exp_irq, base_irq, base_w, base_re, bad, step;
    logic [7:0] s0, s1;

    fill();
    idle(3);
    @(negedge clk); rst = 1'b0;

    // R1: reset state
    bad = 0;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      if (d != 16'h0) bad++;
    end
    chk(bad == 0, "R1 registers zero after reset", bad, 0);
    chk(bus_req == 1'b0 && irq == 2'b00 && mem_re == 1'b0 && mem_we == 1'b0,
        "R1 bus and irq idle", {bus_req, irq, mem_re, mem_we}, 0);

    // table walk on channel 0: R2 R3 R4 R5 R6 R7
    foreach (VEC[k]) begin
      fill();
      modev = {8'h00, VEC[k].cause, VEC[k].dinc, VEC[k].sinc, VEC[k].rpt, VEC[k].word, 1'b1};
      wr(3'd0, {8'h00, VEC[k].src});
      wr(3'd1, {8'h00, VEC[k].dst});
      wr(3'd2, {8'h00, VEC[k].cnt});
      wr(3'd3, modev);
      m_src = VEC[k].src; m_dst = VEC[k].dst; m_cnt = VEC[k].cnt; m_en = 1'b1;
      exp_irq = 0; base_irq = irq0;
      step = VEC[k].word ? 2 : 1;
      for (int t = 0; t < int'(VEC[k].ntrig); t++) begin
        if (VEC[k].cause == 3'd2) wr(3'd3, modev | 16'h0100);
        else pulse(6'(1 << VEC[k].cause), 1);
        idle(10);
        if (m_en) begin
          s0 = expm[m_src]; s1 = expm[8'(m_src + 8'd1)];
          expm[m_dst] = s0;
          if (VEC[k].word) expm[8'(m_dst + 8'd1)] = s1;
          if (m_cnt == 8'd1 && VEC[k].rpt) begin
            m_src = VEC[k].src; m_dst = VEC[k].dst; m_cnt = VEC[k].cnt; exp_irq++;
          end else begin
            if (m_cnt == 8'd1) begin m_en = 1'b0; exp_irq++; end
            m_cnt = m_cnt - 8'd1;
            if (VEC[k].sinc) m_src = 8'(m_src + step);
            if (VEC[k].dinc) m_dst = 8'(m_dst + step);
          end
        end
      end
      bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] != expm[i]) bad++;
      chk(bad == 0, $sformatf("R4 memory contents vector %0d", k), bad, 0);
      rd(3'd2, d);
      chk(d == {8'h00, m_cnt}, $sformatf("R6 count vector %0d", k), d, m_cnt);
      rd(3'd3, d);
      chk(d[0] == m_en && d[7:1] == modev[7:1], $sformatf("R2 mode/enable vector %0d", k), d, {modev[7:1], m_en});
      rd(3'd0, d);
      chk(d == {8'h00, m_src}, $sformatf("R5 source address vector %0d", k), d, m_src);
      rd(3'd1, d);
      chk(d == {8'h00, m_dst}, $sformatf("R7 destination address vector %0d", k), d, m_dst);
      chk(irq0 - base_irq == exp_irq, $sformatf("R6 irq pulses vector %0d", k), irq0 - base_irq, exp_irq);
      wr(3'd3, 16'h0000);
    end

    // R11: disabled channel ignores its line
    wr(3'd4, 16'h0010); wr(3'd5, 16'h00E8); wr(3'd6, 16'h0003);
    wr(3'd7, 16'h0000);
    base_w = wtot;
    pulse(6'b000001, 1); idle(10);
    rd(3'd6, d);
    chk(d == 16'd3 && wtot == base_w, "R11 disabled channel idle", d, 3);

    // R3: other lines and reserved codes do not trigger
    wr(3'd7, {8'h00, 3'd1, 5'b11001});
    pulse(6'b111101, 1); idle(10);
    rd(3'd6, d);
    chk(d == 16'd3 && wtot == base_w, "R3 unselected lines ignored", d, 3);
    wr(3'd7, {8'h00, 3'd6, 5'b11001});
    pulse(6'b111111, 1); wr(3'd7, {8'h00, 3'd6, 5'b11001} | 16'h0100); idle(10);
    rd(3'd6, d);
    chk(d == 16'd3 && wtot == base_w, "R3 reserved cause never fires", d, 3);

    // R9: simultaneous request, channel 0 first
    wr(3'd0, 16'h0001); wr(3'd1, 16'h00E0); wr(3'd2, 16'h0001);
    wr(3'd3, {8'h00, 3'd0, 5'b11001});
    wr(3'd4, 16'h0002); wr(3'd5, 16'h00F0); wr(3'd6, 16'h0001);
    wr(3'd7, {8'h00, 3'd0, 5'b11001});
    base_w = wtot;
    pulse(6'b000001, 1); idle(16);
    chk(wtot - base_w == 2, "R9 both channels served", wtot - base_w, 2);
    chk(wlog[base_w % 64] == 16'h00E0, "R9 channel 0 wins", wlog[base_w % 64], 16'h00E0);
    chk(wlog[(base_w + 1) % 64] == 16'h00F0, "R9 channel 1 second", wlog[(base_w + 1) % 64], 16'h00F0);

    // R8: request held three cycles gives two units
    wr(3'd0, 16'h0008); wr(3'd1, 16'h00E4); wr(3'd2, 16'd10);
    wr(3'd3, {8'h00, 3'd1, 5'b11001});
    base_w = wtot;
    pulse(6'b000010, 3); idle(20);
    rd(3'd2, d);
    chk(d == 16'd8, "R8 merged requests count", d, 8);
    chk(wtot - base_w == 2, "R8 merged requests writes", wtot - base_w, 2);

    // R10: gap between units
    chk(gaps > 0 && min_gap >= 1, "R10 bus released between units", min_gap, 1);

    // R10: no read before grant
    wr(3'd4, 16'h0020); wr(3'd5, 16'h00F8); wr(3'd6, 16'h0002);
    wr(3'd7, {8'h00, 3'd4, 5'b11001});
    @(negedge clk); gnt_hold = 1'b1;
    base_re = retot;
    pulse(6'b010000, 1); idle(10);
    chk(bus_req == 1'b1 && retot == base_re, "R10 waits for grant", retot - base_re, 0);
    @(negedge clk); gnt_hold = 1'b0;
    idle(10);
    rd(3'd6, d);
    chk(d == 16'd1, "R10 unit after grant", d, 1);

    // R1: reset during activity clears state
    @(negedge clk); rst = 1'b1;
    idle(2);
    @(negedge clk); rst = 1'b0;
    rd(3'd7, d);
    chk(d == 16'h0 && bus_req == 1'b0, "R1 reset clears mode", d, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule